// File: doc/BRIEF.md
# Escaping Packet Byte Framer

This block turns a packet stream (a data byte with start and end flags, under a valid/ready handshake) into a flat byte stream for a byte-wide serial link. Each packet goes out behind a three-byte header: a start marker, a channel marker and channel number zero. The end marker is placed in front of the final payload byte, not after it. A payload byte that equals one of the six reserved codes is sent as an escape character followed by the byte XOR 0x20. The escape character used depends on whether the code belongs to the packet layer or to the link layer.

The output side is registered. Once out of reset it always offers a byte, and sends the idle code 0x4A whenever no packet byte is ready, so the link never starves. When `WORD_BYTES` is larger than one, idle pad bytes go in just before the end marker. The number of packet bytes, from the start marker to the last byte, is then a multiple of `WORD_BYTES`, and the end marker and final byte sit at the tail of the aligned length.

Top module: `escaping_byte_framer`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and `out_data` is 0x4A. In the cycle after the first clock edge without reset, `out_valid` is 1 and `out_data` is 0x4A.
- R2: After reset, `out_valid` stays 1. The idle code 0x4A is sent whenever no packet byte is ready to go, including mid-packet while the input has no byte.
- R3: Each packet starts with the three bytes 0x7A, 0x7C, 0x00, and then its payload.
- R4: A payload byte equal to 0x7A, 0x7B, 0x7C or 0x7D is sent as 0x7D followed by the byte XOR 0x20.
- R5: A payload byte equal to 0x4A or 0x4D is sent as 0x4D followed by the byte XOR 0x20.
- R6: The end marker 0x7B is sent immediately before the last payload byte, which is still escaped under R4 and R5. A one-byte packet is sent as 0x7A 0x7C 0x00 0x7B followed by the byte, escaped if needed.
- R7: With `WORD_BYTES` > 1 (a power of two), pad bytes of 0x4A are placed directly before 0x7B. They make the count of packet bytes from 0x7A through the last byte a multiple of `WORD_BYTES`. Idles sent because the input was empty are not counted.
- R8: `in_ready` is 0 in every cycle that sends a start, channel, channel-number, end, escape or pad byte. It is also 0 whenever `out_ready` is 0 while `out_valid` is 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value.
- R10: Between packets, an input byte without the start flag is accepted (`in_ready` = 1) and dropped, and the output keeps sending 0x4A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Payload byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken this cycle |
| out_data | output | 8 | Link byte |
| out_valid | output | 1 | Link byte present |
| out_ready | input | 1 | Link accepts the byte |

## Verification
The bench builds the framer with `WORD_BYTES` = 4. Payload lengths from one to twelve, mixed with escaped final bytes, then reach every pad count from zero to three, and the escaped tail of three bytes shifts the alignment arithmetic. Packets that arrive with no input gaps are compared byte for byte, pads included, and their length is checked against the four-byte boundary. Packets with random input gaps are compared after every 0x4A is removed, which separates starvation idles from pad idles. A random `out_ready` exercises the stall hold throughout.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam logic [7:0] MK_START  = 8'h7A;
  localparam logic [7:0] MK_END    = 8'h7B;
  localparam logic [7:0] MK_CHAN   = 8'h7C;
  localparam logic [7:0] ESC_PKT   = 8'h7D;
  localparam logic [7:0] IDLE_CODE = 8'h4A;
  localparam logic [7:0] ESC_PHY   = 8'h4D;
  localparam logic [7:0] CHAN_ID   = 8'h00;
  localparam logic [7:0] FLIP_MASK = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHAN,
    ST_NUM,
    ST_BODY,
    ST_PAD,
    ST_LAST,
    ST_ESC
  } fr_state_t;
endpackage

// File: rtl/framer_esc_class.sv
module framer_esc_class
  import framer_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       needs_esc,
  output logic [7:0] esc_char,
  output logic [7:0] flipped
);
  logic pkt_hit;
  logic phy_hit;

  always_comb begin
    pkt_hit = (byte_i == MK_START) || (byte_i == MK_END) ||
              (byte_i == MK_CHAN)  || (byte_i == ESC_PKT);
    phy_hit = (byte_i == IDLE_CODE) || (byte_i == ESC_PHY);
  end

  assign needs_esc = pkt_hit || phy_hit;
  assign esc_char  = phy_hit ? ESC_PHY : ESC_PKT;
  assign flipped   = byte_i ^ FLIP_MASK;
endmodule

// File: rtl/framer_align.sv
module framer_align #(
  parameter int WORD_BYTES = 4,
  parameter int CW         = 2
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          tail_esc,
  output logic [CW-1:0] pad_o
);
  generate
    if (WORD_BYTES > 1) begin : g_pad
      logic [CW-1:0] sum;
      logic [CW-1:0] tail_len;
      // tail = end marker + last byte, plus one when that byte is escaped
      assign tail_len = tail_esc ? CW'(3) : CW'(2);
      assign sum      = cnt_i + tail_len;
      assign pad_o    = ~sum + CW'(1);
    end else begin : g_nopad
      logic unused_ok;
      assign unused_ok = ^{cnt_i, tail_esc};
      assign pad_o     = '0;
    end
  endgenerate
endmodule

// File: rtl/escaping_byte_framer.sv
module escaping_byte_framer
  import framer_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready
);
  localparam int CW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  fr_state_t     st, nxt_st;
  logic [CW-1:0] cnt, pad_left, nxt_pad, pad_w;
  logic          esc_last, nxt_esc_last;
  logic [7:0]    data_q, nxt_byte;
  logic          valid_q;
  logic          adv, take, counted, restart;
  logic          needs_esc;
  logic [7:0]    esc_char, flipped;

  framer_esc_class u_cls (
    .byte_i    (in_data),
    .needs_esc (needs_esc),
    .esc_char  (esc_char),
    .flipped   (flipped)
  );

  framer_align #(.WORD_BYTES(WORD_BYTES), .CW(CW)) u_aln (
    .cnt_i    (cnt),
    .tail_esc (needs_esc),
    .pad_o    (pad_w)
  );

  assign adv = out_ready || !valid_q;

  always_comb begin
    nxt_st       = st;
    nxt_byte     = IDLE_CODE;
    nxt_pad      = pad_left;
    nxt_esc_last = esc_last;
    take         = 1'b0;
    counted      = 1'b0;
    restart      = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (in_valid && in_sop) begin
          nxt_byte = MK_START;
          restart  = 1'b1;
          nxt_st   = ST_CHAN;
        end else begin
          take = in_valid;
        end
      end
      ST_CHAN: begin
        nxt_byte = MK_CHAN;
        counted  = 1'b1;
        nxt_st   = ST_NUM;
      end
      ST_NUM: begin
        nxt_byte = CHAN_ID;
        counted  = 1'b1;
        nxt_st   = ST_BODY;
      end
      ST_BODY: begin
        if (in_valid) begin
          counted = 1'b1;
          if (in_eop) begin
            if (pad_w == '0) begin
              nxt_byte = MK_END;
              nxt_st   = ST_LAST;
            end else begin
              nxt_byte = IDLE_CODE;
              nxt_pad  = pad_w - CW'(1);
              nxt_st   = ST_PAD;
            end
          end else if (needs_esc) begin
            nxt_byte     = esc_char;
            nxt_esc_last = 1'b0;
            nxt_st       = ST_ESC;
          end else begin
            nxt_byte = in_data;
            take     = 1'b1;
          end
        end
      end
      ST_PAD: begin
        counted = 1'b1;
        if (pad_left == '0) begin
          nxt_byte = MK_END;
          nxt_st   = ST_LAST;
        end else begin
          nxt_byte = IDLE_CODE;
          nxt_pad  = pad_left - CW'(1);
        end
      end
      ST_LAST: begin
        if (in_valid) begin
          counted = 1'b1;
          if (needs_esc) begin
            nxt_byte     = esc_char;
            nxt_esc_last = 1'b1;
            nxt_st       = ST_ESC;
          end else begin
            nxt_byte = in_data;
            take     = 1'b1;
            nxt_st   = ST_IDLE;
          end
        end
      end
      ST_ESC: begin
        nxt_byte = flipped;
        take     = 1'b1;
        counted  = 1'b1;
        nxt_st   = esc_last ? ST_IDLE : ST_BODY;
      end
      default: nxt_st = ST_IDLE;
    endcase
  end

  assign in_ready = adv && take;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      pad_left <= '0;
      esc_last <= 1'b0;
      data_q   <= IDLE_CODE;
      valid_q  <= 1'b0;
    end else if (adv) begin
      st       <= nxt_st;
      pad_left <= nxt_pad;
      esc_last <= nxt_esc_last;
      data_q   <= nxt_byte;
      valid_q  <= 1'b1;
      if (restart)      cnt <= CW'(1);
      else if (counted) cnt <= cnt + CW'(1);
    end
  end

  assign out_data  = data_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/framer_chk.sv
module framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_ready,
  input logic       out_valid,
  input logic [7:0] out_data
);
  logic xfer;
  assign xfer = out_valid && out_ready;

  // R8
  ready_needs_sink_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (out_ready || !out_valid));

  // R2
  valid_stays_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R4
  pkt_esc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && out_data == 8'h7D) |=> (out_data inside {8'h5A, 8'h5B, 8'h5C, 8'h5D}));

  // R5
  phy_esc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && out_data == 8'h4D) |=> (out_data inside {8'h6A, 8'h6D}));

  // R3
  start_then_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && out_data == 8'h7A) |=> (out_data == 8'h7C));

  // R3
  chan_then_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && out_data == 8'h7C) |=> (out_data == 8'h00));
endmodule

bind escaping_byte_framer framer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_escaping_byte_framer.sv
`timescale 1ns/1ps
module sim_escaping_byte_framer;
  localparam int W = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_sop = 1'b0, in_eop = 1'b0, in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b1;

  int checks = 0, errors = 0;
  int or_mode = 0;
  logic [7:0] pl [0:15];
  logic [7:0] exp_q [$];
  int         exp_len_q [$];
  bit         exp_exact_q [$];
  logic [7:0] frm [$];
  bit in_frm = 0, end_seen = 0, need_more = 0;
  logic [7:0] mb;
  logic [7:0] specials [0:5] = '{8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h4A, 8'h4D};

  always #2 clk = ~clk;

  escaping_byte_framer #(.WORD_BYTES(W)) u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  always @(posedge clk) begin
    #1;
    if (or_mode == 0)      out_ready = 1'b1;
    else if (or_mode == 2) out_ready = 1'b0;
    else                   out_ready = (($urandom % 4) != 0);
  end

  function automatic bit pk_sp(input logic [7:0] b);
    return (b == 8'h7A) || (b == 8'h7B) || (b == 8'h7C) || (b == 8'h7D);
  endfunction
  function automatic bit ph_sp(input logic [7:0] b);
    return (b == 8'h4A) || (b == 8'h4D);
  endfunction

  // expected frame per R3..R7
  task automatic model_frame(input int n, input bit exact);
    logic [7:0] f [$];
    int tail, pad;
    f.push_back(8'h7A); f.push_back(8'h7C); f.push_back(8'h00);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) begin
        tail = (pk_sp(pl[i]) || ph_sp(pl[i])) ? 3 : 2;
        pad  = (W - ((f.size() + tail) % W)) % W;
        repeat (pad) f.push_back(8'h4A);
        f.push_back(8'h7B);
      end
      if (pk_sp(pl[i]))      begin f.push_back(8'h7D); f.push_back(pl[i] ^ 8'h20); end
      else if (ph_sp(pl[i])) begin f.push_back(8'h4D); f.push_back(pl[i] ^ 8'h20); end
      else f.push_back(pl[i]);
    end
    foreach (f[k]) exp_q.push_back(f[k]);
    exp_len_q.push_back(f.size());
    exp_exact_q.push_back(exact);
  endtask

  task automatic finish_frame();
    logic [7:0] e [$];
    logic [7:0] g [$];
    int n;
    bit exact, bad;
    in_frm = 0;
    checks++;
    if (exp_len_q.size() == 0) begin
      errors++;
      $display("FAIL R3 unexpected frame: got %0d bytes exp none", frm.size());
      return;
    end
    n = exp_len_q.pop_front();
    exact = exp_exact_q.pop_front();
    for (int k = 0; k < n; k++) e.push_back(exp_q.pop_front());
    foreach (frm[k]) g.push_back(frm[k]);
    if (!exact) begin
      for (int k = e.size() - 1; k >= 0; k--) if (e[k] == 8'h4A) e.delete(k);
      for (int k = g.size() - 1; k >= 0; k--) if (g[k] == 8'h4A) g.delete(k);
    end
    bad = (e.size() != g.size());
    for (int k = 0; k < e.size() && k < g.size(); k++) if (e[k] != g[k]) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL R3 R4 R5 R6 frame: got %0d bytes exp %0d", g.size(), e.size());
      for (int k = 0; k < e.size() && k < g.size(); k++)
        if (e[k] != g[k]) $display("  byte %0d got %h exp %h", k, g[k], e[k]);
    end
    if (exact) begin
      checks++;
      if ((frm.size() % W) != 0) begin
        errors++;
        $display("FAIL R7 aligned length: got %0d exp multiple of %0d", frm.size(), W);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      mb = out_data;
      if (!in_frm) begin
        if (mb == 8'h7A) begin
          in_frm = 1; end_seen = 0; need_more = 0;
          frm.delete(); frm.push_back(mb);
        end else begin
          checks++;
          if (mb != 8'h4A) begin
            errors++;
            $display("FAIL R10 byte outside frame: got %h exp 4a", mb);
          end
        end
      end else begin
        frm.push_back(mb);
        if (need_more) finish_frame();
        else if (end_seen) begin
          if (mb == 8'h7D || mb == 8'h4D) need_more = 1;
          else finish_frame();
        end else if (mb == 8'h7B) end_seen = 1;
      end
    end
  end

  task automatic send_pkt(input int n, input bit gaps);
    bit acc;
    model_frame(n, !gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) repeat ($urandom % 3) begin @(posedge clk); #1; end
      in_valid = 1; in_data = pl[i]; in_sop = (i == 0); in_eop = (i == n - 1);
      do begin
        @(negedge clk); acc = in_ready;
        @(posedge clk); #1;
      end while (!acc);
      in_valid = 0; in_sop = 0; in_eop = 0;
    end
  endtask

  task automatic expect_ready(input bit e, input string tag);
    @(negedge clk);
    checks++;
    if (in_ready !== e) begin
      errors++;
      $display("FAIL %s in_ready: got %b exp %b", tag, in_ready, e);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: got hang exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] snap;
    void'($urandom(32'd20240611));
    // R1 reset values
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 8'h4A) begin
      errors++;
      $display("FAIL R1 during reset: got %b/%h exp 0/4a", out_valid, out_data);
    end
    @(posedge clk); #1; rst = 0;
    @(posedge clk); @(negedge clk);
    checks++;
    if (out_valid !== 1'b1 || out_data !== 8'h4A) begin
      errors++;
      $display("FAIL R1 after reset: got %b/%h exp 1/4a", out_valid, out_data);
    end
    // R2 idle stream
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b1 || out_data !== 8'h4A) begin
        errors++;
        $display("FAIL R2 idle: got %b/%h exp 1/4a", out_valid, out_data);
      end
    end
    @(posedge clk); #1;
    // R10 stray bytes between packets
    in_valid = 1; in_sop = 0; in_eop = 0; in_data = 8'h7A;
    expect_ready(1, "R10");
    in_data = 8'h33;
    expect_ready(1, "R10");
    in_valid = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (out_data !== 8'h4A) begin
        errors++;
        $display("FAIL R10 output after stray: got %h exp 4a", out_data);
      end
    end
    @(posedge clk); #1;
    // R8 ready pattern around header, pads and end marker
    pl[0] = 8'h11; pl[1] = 8'h22;
    model_frame(2, 1);
    in_valid = 1; in_sop = 1; in_eop = 0; in_data = 8'h11;
    expect_ready(0, "R8 start"); expect_ready(0, "R8 chan"); expect_ready(0, "R8 num");
    expect_ready(1, "R8 body");
    in_sop = 0; in_eop = 1; in_data = 8'h22;
    expect_ready(0, "R8 pad"); expect_ready(0, "R8 pad"); expect_ready(0, "R8 end");
    expect_ready(1, "R8 last");
    in_valid = 0; in_eop = 0;
    repeat (4) begin @(posedge clk); #1; end
    // R6 one-byte packets, each reserved code and a plain byte
    for (int s = 0; s < 7; s++) begin
      pl[0] = (s < 6) ? specials[s] : 8'h55;
      send_pkt(1, 0);
    end
    // R4 R5 all reserved codes in the body
    for (int s = 0; s < 6; s++) pl[s] = specials[s];
    pl[6] = 8'h00;
    send_pkt(7, 0);
    // R9 stall while a packet is in flight
    pl[0] = 8'h01; pl[1] = 8'h7B; pl[2] = 8'h4A; pl[3] = 8'h02; pl[4] = 8'h03;
    fork
      send_pkt(5, 0);
      begin
        repeat (3) @(posedge clk); #1;
        or_mode = 2;
        repeat (2) @(negedge clk);
        snap = out_data;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          checks++;
          if (out_data !== snap || in_ready !== 1'b0) begin
            errors++;
            $display("FAIL R9 stall: got %h/%b exp %h/0", out_data, in_ready, snap);
          end
        end
        or_mode = 0;
      end
    join
    // random packets, R7 across all pad counts
    or_mode = 1;
    for (int p = 0; p < 80; p++) begin
      int n;
      n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++)
        pl[i] = (($urandom % 3) == 0) ? specials[$urandom % 6] : 8'($urandom);
      send_pkt(n, ($urandom % 2) == 1);
      repeat ($urandom % 4) begin @(posedge clk); #1; end
    end
    or_mode = 0;
    repeat (60) begin @(posedge clk); #1; end
    checks++;
    if (exp_len_q.size() != 0) begin
      errors++;
      $display("FAIL R6 frames unfinished: got %0d exp 0", exp_len_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule